// File: doc/BRIEF.md
# Clock Divider Tree with Mode Select

This block produces a family of system clocks (processor, half-rate processor, 66 MHz, 33 MHz, interrupt-controller, 48 MHz and reference groups) from one fast base clock using integer counters. The external clock sources are treated as plain digital signals sampled by the base clock. A three-bit select code `{sel_fast, fsel[1], fsel[0]}` is captured while the synchronous reset `rst_n` is low. It places the whole tree in one of four states:
- `ST_HIZ`: output enable low, outputs quiet.
- `ST_RUN100`: 200 MHz base clock.
- `ST_RUN133`: 400 MHz base clock.
- `ST_TEST`: every counter advances once per rising edge of `tclk_in`.

The state machine has exactly one transition, `T_LOAD`, taken on every clock edge with `rst_n` low: it reloads the state from the decoded code. With `rst_n` high the state holds (`T_HOLD`). A strap input, also captured in reset, chooses between two rates for the interrupt-controller clock: one quarter of the processor rate, or a fixed rate of about 16.67 MHz. The 66 MHz group can be halted by an active-low stop input. The 48 MHz output is gated by `fsel[0]`. All counters leave reset together, so related rising edges coincide.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: Codes 000, 001 and 101 select `ST_HIZ`: `out_oe` is 0 and every clock output stays 0.
- R2: Codes 010/011 (`ST_RUN100`) divide the base clock as follows (period/high in base cycles): processor 2/1, half-rate 4/2, 66 group 3/2, 33 group 6/3.
- R3: Codes 110/111 (`ST_RUN133`) divide the base clock as follows: processor 3/2, half-rate 6/3, 66 group 6/3, 33 group 12/6.
- R4: Code 100 (`ST_TEST`) gives each output's period as a multiple of the `tclk_in` period:
  - processor ×2, half-rate ×4, 66 group ×4, 33 group ×8;
  - 48 output ×2, interrupt-controller ×16;
  - reference ×1 (it follows `tclk_in`).
- R5: With `apic_strap_n`=1 the interrupt-controller period is four processor periods (8 base cycles at 100, 12 at 133). With `apic_strap_n`=0 the period is 12 base cycles at 100 and 24 at 133.
- R6: In the run states, `fsel[0]`=1 passes `c48_in` to `out_48` with its period unchanged, and `fsel[0]`=0 holds `out_48` at 0.
- R7: While `cpu_stop_n` is 0, the 66 group stays low from its next counter boundary on. The other groups keep running.
- R8: After `cpu_stop_n` returns to 1, the 66 group's first high phase has full length (no runt pulse).
- R9: Every rising edge of `out_apic` coincides with a rising edge of `out_cpu`.
- R10: Changes of the select code or the strap while `rst_n` is 1 have no effect on rates or on `out_oe`.
- R11: All lanes of a group carry identical waveforms.
- R12: While `rst_n` is 0, `out_oe` and all clock outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset; captures code and strap |
| sel_fast | input | 1 | Ratio-set select, most significant bit of the code |
| fsel | input | 2 | Function select, low two bits of the code |
| apic_strap_n | input | 1 | 0 selects the fixed interrupt-controller rate |
| cpu_stop_n | input | 1 | Active-low halt of the 66 group |
| tclk_in | input | 1 | External test clock (sampled) |
| ref_in | input | 1 | Reference clock source (sampled) |
| c48_in | input | 1 | 48 MHz source (sampled) |
| out_oe | output | 1 | Output enable for all groups |
| out_cpu | output | N_CPU | Processor clocks |
| out_half | output | N_HALF | Half-rate processor clocks |
| out_g66 | output | N_G66 | 66 MHz group |
| out_g33 | output | N_G33 | 33 MHz group |
| out_apic | output | N_APIC | Interrupt-controller clocks |
| out_48 | output | 1 | 48 MHz output |
| out_ref | output | N_REF | Reference outputs |

## Verification
The checks assume that `cpu_stop_n` and the select inputs are synchronous to the base clock and steady across the release of reset, because the stop property relates a 66-group rise to the stop level one cycle earlier. The sampled sources must also be much slower than the base clock. The stimulus changes every input on the falling edge of the base clock and holds the code and strap constant through each reset pulse. It runs the test clock at eight base cycles per period, `c48_in` at six and `ref_in` at fourteen, so every edge is seen by the sampling flops.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int DIV_W = 5;

    typedef enum logic [1:0] {
        ST_HIZ    = 2'd0,
        ST_RUN100 = 2'd1,
        ST_RUN133 = 2'd2,
        ST_TEST   = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        CH_CPU  = 3'd0,
        CH_HALF = 3'd1,
        CH_G66  = 3'd2,
        CH_G33  = 3'd3,
        CH_APIC = 3'd4,
        CH_48   = 3'd5
    } chan_e;

    localparam int NUM_CH = 6;

    // code = {sel_fast, fsel[1], fsel[0]}
    function automatic mode_e decode_mode(input logic [2:0] code);
        mode_e m;
        case (code)
            3'b010, 3'b011: m = ST_RUN100;
            3'b110, 3'b111: m = ST_RUN133;
            3'b100:         m = ST_TEST;
            default:        m = ST_HIZ;
        endcase
        return m;
    endfunction

    // divisor in counter ticks for each channel and state
    function automatic int divisor(input mode_e m, input chan_e c, input logic apic_fixed);
        int d;
        d = 2;
        case (m)
            ST_RUN100: begin
                case (c)
                    CH_CPU:  d = 2;
                    CH_HALF: d = 4;
                    CH_G66:  d = 3;
                    CH_G33:  d = 6;
                    CH_APIC: d = apic_fixed ? 12 : 8;
                    default: d = 2;
                endcase
            end
            ST_RUN133: begin
                case (c)
                    CH_CPU:  d = 3;
                    CH_HALF: d = 6;
                    CH_G66:  d = 6;
                    CH_G33:  d = 12;
                    CH_APIC: d = apic_fixed ? 24 : 12;
                    default: d = 2;
                endcase
            end
            ST_TEST: begin
                case (c)
                    CH_CPU:  d = 2;
                    CH_HALF: d = 4;
                    CH_G66:  d = 4;
                    CH_G33:  d = 8;
                    CH_APIC: d = 16;
                    default: d = 2;
                endcase
            end
            default: d = 2;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/clkgen_mode_fsm.sv
module clkgen_mode_fsm
    import clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] code,
    input  logic       strap_n,
    output mode_e      mode,
    output logic       apic_fixed,
    output logic       en48,
    output logic       active,
    output logic       test_mode
);

    mode_e state;
    logic  running;
    logic  fixed_q;
    logic  en48_q;

    // state register: T_LOAD in reset, T_HOLD otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= decode_mode(code);
            fixed_q <= ~strap_n;
            en48_q  <= code[0];
            running <= 1'b0;
        end else begin
            running <= 1'b1;
        end
    end

    // outputs of each state
    always_comb begin
        mode       = state;
        apic_fixed = fixed_q;
        en48       = 1'b0;
        active     = 1'b0;
        test_mode  = 1'b0;
        unique case (state)
            ST_HIZ: begin
                active = 1'b0;
            end
            ST_RUN100, ST_RUN133: begin
                active = running;
                en48   = en48_q;
            end
            ST_TEST: begin
                active    = running;
                test_mode = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/clkgen_tick_gen.sv
module clkgen_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic tclk_in,
    input  logic ref_in,
    input  logic c48_in,
    output logic tick,
    output logic tclk_lvl,
    output logic ref_lvl,
    output logic c48_lvl
);

    localparam int NSIG = 3;

    logic [NSIG-1:0] stg [SYNC_STAGES];
    logic            tclk_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            tclk_prev <= 1'b0;
        end else begin
            stg[0] <= {c48_in, ref_in, tclk_in};
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            tclk_prev <= stg[SYNC_STAGES-1][0];
        end
    end

    assign tclk_lvl = stg[SYNC_STAGES-1][0];
    assign ref_lvl  = stg[SYNC_STAGES-1][1];
    assign c48_lvl  = stg[SYNC_STAGES-1][2];
    assign tick     = test_mode ? (tclk_lvl & ~tclk_prev) : 1'b1;

endmodule

// File: rtl/clkgen_div_chan.sv
module clkgen_div_chan #(
    parameter int CNT_W = 5,
    parameter bit GATED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] div,
    input  logic             run,
    input  logic             stop_n,
    output logic             q
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hi;
    logic             last;
    logic             en;
    logic             en_src;

    assign hi     = (div + CNT_W'(1)) >> 1;
    assign last   = (cnt == div - CNT_W'(1));
    assign en_src = GATED ? stop_n : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            en  <= en_src;
            q   <= 1'b0;
        end else begin
            if (!run) begin
                en <= en_src;
            end else if (tick) begin
                cnt <= last ? '0 : cnt + CNT_W'(1);
                if (last) en <= en_src;
            end
            q <= run && en && (cnt < hi);
        end
    end

endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
    import clkgen_pkg::*;
#(
    parameter int N_CPU       = 6,
    parameter int N_HALF      = 2,
    parameter int N_G66       = 4,
    parameter int N_G33       = 2,
    parameter int N_APIC      = 6,
    parameter int N_REF       = 2,
    parameter int CNT_W       = DIV_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_fast,
    input  logic [1:0]        fsel,
    input  logic              apic_strap_n,
    input  logic              cpu_stop_n,
    input  logic              tclk_in,
    input  logic              ref_in,
    input  logic              c48_in,
    output logic              out_oe,
    output logic [N_CPU-1:0]  out_cpu,
    output logic [N_HALF-1:0] out_half,
    output logic [N_G66-1:0]  out_g66,
    output logic [N_G33-1:0]  out_g33,
    output logic [N_APIC-1:0] out_apic,
    output logic              out_48,
    output logic [N_REF-1:0]  out_ref
);

    logic [2:0]        code;
    mode_e             mode;
    logic              apic_fixed;
    logic              en48;
    logic              active;
    logic              test_mode;
    logic              tick;
    logic              tclk_lvl;
    logic              ref_lvl;
    logic              c48_lvl;
    logic [NUM_CH-1:0] div_q;
    logic              q48_r;
    logic              ref_r;

    assign code = {sel_fast, fsel};

    clkgen_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .code       (code),
        .strap_n    (apic_strap_n),
        .mode       (mode),
        .apic_fixed (apic_fixed),
        .en48       (en48),
        .active     (active),
        .test_mode  (test_mode)
    );

    clkgen_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .tclk_in   (tclk_in),
        .ref_in    (ref_in),
        .c48_in    (c48_in),
        .tick      (tick),
        .tclk_lvl  (tclk_lvl),
        .ref_lvl   (ref_lvl),
        .c48_lvl   (c48_lvl)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic [CNT_W-1:0] dv;
        assign dv = CNT_W'(divisor(mode, chan_e'(g), apic_fixed));
        clkgen_div_chan #(
            .CNT_W (CNT_W),
            .GATED (g == int'(CH_G66))
        ) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .div    (dv),
            .run    (active),
            .stop_n (cpu_stop_n),
            .q      (div_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q48_r <= 1'b0;
            ref_r <= 1'b0;
        end else begin
            q48_r <= active & ~test_mode & en48 & c48_lvl;
            ref_r <= active & (test_mode ? tclk_lvl : ref_lvl);
        end
    end

    assign out_oe   = active;
    assign out_cpu  = {N_CPU{div_q[CH_CPU]}};
    assign out_half = {N_HALF{div_q[CH_HALF]}};
    assign out_g66  = {N_G66{div_q[CH_G66]}};
    assign out_g33  = {N_G33{div_q[CH_G33]}};
    assign out_apic = {N_APIC{div_q[CH_APIC]}};
    assign out_48   = test_mode ? div_q[CH_48] : q48_r;
    assign out_ref  = {N_REF{ref_r}};

endmodule

// File: rtl/clkgen_mode_ctrl_chk.sv
module clkgen_mode_ctrl_chk #(
    parameter int N_CPU  = 6,
    parameter int N_G66  = 4,
    parameter int N_APIC = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_stop_n,
    input logic              out_oe,
    input logic [N_CPU-1:0]  out_cpu,
    input logic [N_G66-1:0]  out_g66,
    input logic [N_APIC-1:0] out_apic,
    input logic              out_48
);

    p_quiet_when_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_oe |-> (out_cpu == '0 && out_g66 == '0 && out_apic == '0 && !out_48));

    p_oe_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> $stable(out_oe));

    p_apic_on_cpu_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_apic[0]) |-> $rose(out_cpu[0]));

    p_g66_start_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_g66[0]) |-> $past(cpu_stop_n));

    p_cpu_lanes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cpu == '0) || (out_cpu == '1));

endmodule

bind clkgen_mode_ctrl clkgen_mode_ctrl_chk #(
    .N_CPU  (N_CPU),
    .N_G66  (N_G66),
    .N_APIC (N_APIC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_stop_n (cpu_stop_n),
    .out_oe     (out_oe),
    .out_cpu    (out_cpu),
    .out_g66    (out_g66),
    .out_apic   (out_apic),
    .out_48     (out_48)
);

// File: tb/test_clkgen_mode_ctrl.sv
`timescale 1ns/1ps
module test_clkgen_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_fast = 1'b0;
    logic [1:0] fsel = 2'b00;
    logic       apic_strap_n = 1'b1;
    logic       cpu_stop_n = 1'b1;
    logic       tclk_in = 1'b0;
    logic       ref_in = 1'b0;
    logic       c48_in = 1'b0;
    logic       out_oe;
    logic [5:0] out_cpu;
    logic [1:0] out_half;
    logic [3:0] out_g66;
    logic [1:0] out_g33;
    logic [5:0] out_apic;
    logic       out_48;
    logic [1:0] out_ref;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    ch;
        int    per;
        int    hi;
        string req;
    } exp_t;

    exp_t exp_q[$];
    bit   mon_busy = 1'b0;

    always #5 clk = ~clk;

    clkgen_mode_ctrl i_clkgen_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_fast(sel_fast), .fsel(fsel),
        .apic_strap_n(apic_strap_n), .cpu_stop_n(cpu_stop_n),
        .tclk_in(tclk_in), .ref_in(ref_in), .c48_in(c48_in),
        .out_oe(out_oe), .out_cpu(out_cpu), .out_half(out_half),
        .out_g66(out_g66), .out_g33(out_g33), .out_apic(out_apic),
        .out_48(out_48), .out_ref(out_ref)
    );

    // sources: test clock 8 cycles, 48 source 6, reference 14
    initial forever begin repeat (4) @(negedge clk); tclk_in = ~tclk_in; end
    initial forever begin repeat (3) @(negedge clk); c48_in = ~c48_in; end
    initial forever begin repeat (7) @(negedge clk); ref_in = ~ref_in; end

    function automatic logic pick(input int ch);
        case (ch)
            0: return out_cpu[0];
            1: return out_half[0];
            2: return out_g66[0];
            3: return out_g33[0];
            4: return out_apic[0];
            5: return out_48;
            default: return out_ref[0];
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic measure(input int ch, output int per, output int hi);
        logic prev, cur;
        int   n;
        per = -1; hi = -1;
        if (ch < 0) return;
        @(negedge clk); prev = pick(ch);
        n = 0;
        while (n < 600) begin
            @(negedge clk); cur = pick(ch); n++;
            if (!prev && cur) break;
            prev = cur;
        end
        if (n >= 600) return;
        hi = 1;
        while (pick(ch) && hi < 600) begin @(negedge clk); if (pick(ch)) hi++; end
        per = hi;
        while (!pick(ch) && per < 1200) begin @(negedge clk); per++; end
    endtask

    task automatic count_high(input int ch, input int len, output int ones);
        ones = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pick(ch)) ones++;
        end
    endtask

    // monitor: pops expectations and compares against measured waveforms
    initial forever begin
        exp_t it;
        int   per, hi, ones;
        wait (exp_q.size() > 0);
        mon_busy = 1'b1;
        it = exp_q.pop_front();
        if (it.per == 0) begin
            count_high(it.ch, 150, ones);
            check(ones == 0, it.req, $sformatf("ch%0d held low, high samples", it.ch), ones, 0);
        end else begin
            measure(it.ch, per, hi);
            check(per == it.per, it.req, $sformatf("ch%0d period", it.ch), per, it.per);
            check(hi == it.hi, it.req, $sformatf("ch%0d high time", it.ch), hi, it.hi);
        end
        mon_busy = 1'b0;
    end

    task automatic expect_clk(input int ch, input int per, input int hi, input string req);
        exp_t it;
        it.ch = ch; it.per = per; it.hi = hi; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic drain();
        @(negedge clk);
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    task automatic start_mode(input logic [2:0] code, input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        {sel_fast, fsel} = code;
        apic_strap_n = strap;
        repeat (4) @(negedge clk);
        // R12: quiet during reset
        check(out_oe == 1'b0 && out_cpu == '0 && out_g66 == '0 && out_apic == '0 && out_48 == 1'b0,
              "R12", "reset outputs", int'(out_oe), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_quiet(input string req);
        int ones = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (out_oe || out_cpu != '0 || out_half != '0 || out_g66 != '0 ||
                out_g33 != '0 || out_apic != '0 || out_48 || out_ref != '0) ones++;
        end
        check(ones == 0, req, "tri-state code, active samples", ones, 0);
    endtask

    task automatic check_align(input string req);
        logic pa, pc;
        int   bad = 0;
        int   seen = 0;
        @(negedge clk); pa = out_apic[0]; pc = out_cpu[0];
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!pa && out_apic[0]) begin
                seen++;
                if (!(!pc && out_cpu[0])) bad++;
            end
            pa = out_apic[0]; pc = out_cpu[0];
        end
        check(bad == 0 && seen > 0, req, "interrupt-clock rise without processor rise", bad, 0);
    endtask

    task automatic check_lanes(input string req);
        int bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!(out_cpu == '0 || out_cpu == '1)) bad++;
            if (!(out_g66 == '0 || out_g66 == '1)) bad++;
            if (!(out_apic == '0 || out_apic == '1)) bad++;
            if (out_half[0] != out_half[1] || out_ref[0] != out_ref[1]) bad++;
        end
        check(bad == 0, req, "lane mismatches", bad, 0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: tri-state and reserved codes
        start_mode(3'b000, 1'b1); check_quiet("R1");
        start_mode(3'b001, 1'b1); check_quiet("R1");
        start_mode(3'b101, 1'b1); check_quiet("R1");

        // R2 / R5 / R6 at 100 MHz set, strap open, 48 off
        start_mode(3'b010, 1'b1);
        check(out_oe == 1'b1, "R2", "enable", int'(out_oe), 1);
        expect_clk(0, 2, 1, "R2");
        expect_clk(1, 4, 2, "R2");
        expect_clk(2, 3, 2, "R2");
        expect_clk(3, 6, 3, "R2");
        expect_clk(4, 8, 4, "R5");
        expect_clk(5, 0, 0, "R6");
        expect_clk(6, 14, 7, "R6");
        drain();
        check_align("R9");
        check_lanes("R11");

        // 100 MHz set, fixed interrupt rate, 48 on
        start_mode(3'b011, 1'b0);
        expect_clk(4, 12, 6, "R5");
        expect_clk(5, 6, 3, "R6");
        drain();

        // R7: stop the 66 group
        cpu_stop_n = 1'b0;
        repeat (10) @(negedge clk);
        expect_clk(2, 0, 0, "R7");
        expect_clk(0, 2, 1, "R7");
        drain();
        // R8: restart with full first high phase
        cpu_stop_n = 1'b1;
        expect_clk(2, 3, 2, "R8");
        drain();

        // R10: live changes to code and strap are ignored
        fsel = 2'b00; sel_fast = 1'b0; apic_strap_n = 1'b1;
        repeat (5) @(negedge clk);
        check(out_oe == 1'b1, "R10", "enable after code change", int'(out_oe), 1);
        expect_clk(4, 12, 6, "R10");
        expect_clk(0, 2, 1, "R10");
        drain();

        // R3 at 133 MHz set
        start_mode(3'b111, 1'b1);
        expect_clk(0, 3, 2, "R3");
        expect_clk(1, 6, 3, "R3");
        expect_clk(2, 6, 3, "R3");
        expect_clk(3, 12, 6, "R3");
        expect_clk(4, 12, 6, "R5");
        expect_clk(5, 6, 3, "R6");
        drain();
        check_align("R9");

        start_mode(3'b110, 1'b0);
        expect_clk(4, 24, 12, "R5");
        expect_clk(5, 0, 0, "R6");
        drain();
        check_align("R9");

        // R4: test mode, test clock period 8
        start_mode(3'b100, 1'b1);
        expect_clk(0, 16, 8, "R4");
        expect_clk(1, 32, 16, "R4");
        expect_clk(2, 32, 16, "R4");
        expect_clk(3, 64, 32, "R4");
        expect_clk(5, 16, 8, "R4");
        expect_clk(4, 128, 64, "R4");
        expect_clk(6, 8, 4, "R4");
        drain();
        check_align("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule